// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetch Engine

This block is the transmit half of a descriptor-driven network controller. Software builds frames in memory and describes each one with a 16-byte descriptor. The descriptors form a ring starting at a 256-byte-aligned base address. Software writes the ring base through a small register port, hands descriptors to the hardware by setting their ownership flag, and rings a doorbell. The engine then walks the ring. For each owned descriptor it reads the status word and the buffer address. It streams the frame out one byte per beat on a byte-wide output, with a marker on the final byte. It then writes the status word back with the ownership flag cleared, so that software can see that the descriptor is finished.

Frames shorter than the minimum length are padded with zero bytes up to that length. After a descriptor flagged as ring end, the engine goes back to the ring base. Otherwise it moves on by one descriptor. When it meets a descriptor that software does not own over to it, the engine parks and waits for the next doorbell. Memory is reached through a simple synchronous port whose read data arrives one cycle after the request.

Top module: `txring_fetch`

## Requirements
- R1: After reset the engine issues no memory request and drives no output byte until a doorbell write arrives.
- R2: A register write to offset 0x38 starts the engine only if bit 6 of the written data is set. A write there with bit 6 clear has no effect.
- R3: The descriptor is four 32-bit words. The status word sits at byte offset 0, the buffer address at offset 8, and the words at offsets 4 and 12 are never used. In the status word, bit 31 is the hardware-owned flag, bit 30 is the ring-end flag, and bits 15:0 hold the frame length in bytes.
- R4: The output carries the buffer bytes in ascending address order. The byte at address A comes from bits 8*(A mod 4)+7 down to 8*(A mod 4) of the word at A rounded down to a multiple of 4. The buffer may start at any byte address.
- R5: The number of bytes sent is the larger of the length field and 60. Every byte beyond the length field is zero, and a length of 0 gives 60 zero bytes.
- R6: The last-byte marker is high on exactly one byte per frame, which is the final byte sent.
- R7: After the final byte, the engine writes the status word back to the descriptor with bit 31 cleared and every other bit unchanged.
- R8: After a descriptor whose ring-end flag is set, the next descriptor fetched is at the ring base. Otherwise the next one is at the current address plus 16.
- R9: A fetched status word with bit 31 clear stops the engine: it sends nothing and writes nothing back. Descriptors that software later hands over are not fetched until the next doorbell write.
- R10: A write to offset 0x20 sets the ring base to the written value with its low 8 bits forced to zero, and moves the next fetch to that base.
- R11: Every memory read is word aligned. The only memory writes are status write-backs to 16-byte-aligned descriptor addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable (read when low) |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read request |
| tx_valid | output | 1 | Output byte valid |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The hardest cases to reach are the ones at the ends of the ring. The first is the wrap after a ring-end descriptor, followed by the engine finding a descriptor it has already retired and stopping on it. The second is a descriptor handed over without a doorbell, which must stay untouched. The stimulus drives a table of frames through a three-slot ring, so the pointer wraps twice and then lands on a slot that was already retired. A doorbell at that point must give only a single status read. The bench then hands over that slot, first with no doorbell and then with a doorbell byte whose start bit is clear, and expects silence in both cases. Only a proper doorbell should release the frame. The frame lengths cover zero, short, exactly 60, 61 and long, with buffer start offsets covering all four byte lanes.

// File: rtl/txr_pkg.sv
package txr_pkg;
   localparam int WORD_W     = 32;
   localparam int OWN_BIT    = 31;
   localparam int EOR_BIT    = 30;
   localparam int DOORBELL_B = 6;
   localparam logic [7:0] OFS_RING_BASE = 8'h20;
   localparam logic [7:0] OFS_DOORBELL  = 8'h38;
   localparam int BUFPTR_OFS = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_STAT_RQ,
      ST_STAT_WT,
      ST_ADDR_RQ,
      ST_ADDR_WT,
      ST_DATA_RQ,
      ST_DATA_WT,
      ST_EMIT,
      ST_RETIRE
   } txr_state_e;
endpackage

// File: rtl/tx_ring_regs.sv
module tx_ring_regs
   import txr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int ALIGN_BITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [WORD_W-1:0] reg_wdata,
   input  logic              stop_req,
   output logic [AW-1:0]     ring_base,
   output logic [AW-1:0]     base_new,
   output logic              base_wr,
   output logic              armed
);
   logic poll_hit;
   logic unused_bits;

   assign base_wr  = reg_wr && (reg_addr == OFS_RING_BASE);
   assign poll_hit = reg_wr && (reg_addr == OFS_DOORBELL) && reg_wdata[DOORBELL_B];
   assign base_new = {reg_wdata[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   assign unused_bits = ^{reg_wdata[ALIGN_BITS-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ring_base <= '0;
         armed     <= 1'b0;
      end else begin
         if (base_wr) ring_base <= base_new;
         if (poll_hit)      armed <= 1'b1;
         else if (stop_req) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/tx_lane_sel.sv
module tx_lane_sel
   import txr_pkg::*;
#(
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic [WORD_W-1:0] word,
   input  logic [1:0]        lane,
   input  logic              in_payload,
   output logic [7:0]        byte_out
);
   logic [1:0] phys_lane;

   generate
      if (BIG_ENDIAN) begin : g_be
         assign phys_lane = 2'd3 - lane;
      end else begin : g_le
         assign phys_lane = lane;
      end
   endgenerate

   always_comb begin
      byte_out = 8'h00;
      if (in_payload) byte_out = word[8*phys_lane +: 8];
   end
endmodule

// File: rtl/tx_ring_ctrl.sv
module tx_ring_ctrl
   import txr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LEN_W      = 16,
   parameter int MIN_FRAME  = 60,
   parameter int DESC_BYTES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              armed,
   input  logic [AW-1:0]     ring_base,
   input  logic [AW-1:0]     base_new,
   input  logic              base_wr,
   output logic              stop_req,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              tx_valid,
   output logic              tx_last,
   output logic [1:0]        lane,
   output logic              in_payload,
   output logic [WORD_W-1:0] word_q
);
   localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(MIN_FRAME);

   txr_state_e        state_q;
   logic [AW-1:0]     cur_q;
   logic [WORD_W-1:0] stat_q;
   logic [AW-1:0]     buf_q;
   logic [LEN_W-1:0]  idx_q;
   logic [LEN_W-1:0]  len;
   logic [LEN_W-1:0]  send_len;
   logic [AW-1:0]     byte_addr;
   logic [LEN_W:0]    idx_nx;
   logic [1:0]        lane_nx;
   logic              more_payload;

   assign len          = stat_q[LEN_W-1:0];
   assign send_len     = (len < MIN_LEN) ? MIN_LEN : len;
   assign byte_addr    = buf_q + AW'(idx_q);
   assign idx_nx       = {1'b0, idx_q} + 1'b1;
   assign lane_nx      = byte_addr[1:0] + 2'd1;
   assign more_payload = idx_nx < {1'b0, len};
   assign lane         = byte_addr[1:0];
   assign in_payload   = idx_q < len;
   assign tx_valid     = (state_q == ST_EMIT);
   assign tx_last      = tx_valid && (idx_q == send_len - 1'b1);
   assign stop_req     = (state_q == ST_STAT_WT) && !mem_rdata[OWN_BIT];

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q;
      mem_wdata = stat_q & ~(WORD_W'(1) << OWN_BIT);
      case (state_q)
         ST_STAT_RQ: mem_req = 1'b1;
         ST_ADDR_RQ: begin
            mem_req  = 1'b1;
            mem_addr = cur_q + AW'(BUFPTR_OFS);
         end
         ST_DATA_RQ: begin
            mem_req  = 1'b1;
            mem_addr = {byte_addr[AW-1:2], 2'b00};
         end
         ST_RETIRE: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cur_q   <= '0;
         stat_q  <= '0;
         buf_q   <= '0;
         idx_q   <= '0;
         word_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE:    if (armed) state_q <= ST_STAT_RQ;
            ST_STAT_RQ: state_q <= ST_STAT_WT;
            ST_STAT_WT: begin
               stat_q  <= mem_rdata;
               state_q <= mem_rdata[OWN_BIT] ? ST_ADDR_RQ : ST_IDLE;
            end
            ST_ADDR_RQ: state_q <= ST_ADDR_WT;
            ST_ADDR_WT: begin
               buf_q   <= mem_rdata[AW-1:0];
               idx_q   <= '0;
               state_q <= (len == '0) ? ST_EMIT : ST_DATA_RQ;
            end
            ST_DATA_RQ: state_q <= ST_DATA_WT;
            ST_DATA_WT: begin
               word_q  <= mem_rdata;
               state_q <= ST_EMIT;
            end
            ST_EMIT: begin
               if (tx_last) begin
                  state_q <= ST_RETIRE;
               end else begin
                  idx_q   <= idx_nx[LEN_W-1:0];
                  state_q <= (more_payload && lane_nx == 2'd0) ? ST_DATA_RQ : ST_EMIT;
               end
            end
            ST_RETIRE: begin
               cur_q   <= stat_q[EOR_BIT] ? ring_base : cur_q + AW'(DESC_BYTES);
               state_q <= ST_STAT_RQ;
            end
            default: state_q <= ST_IDLE;
         endcase
         if (base_wr) cur_q <= base_new;
      end
   end
endmodule

// File: rtl/txring_fetch.sv
module txring_fetch
   import txr_pkg::*;
#(
   parameter int AW         = 32,
   parameter int LEN_W      = 16,
   parameter int MIN_FRAME  = 60,
   parameter int DESC_BYTES = 16,
   parameter int ALIGN_BITS = 8,
   parameter bit BIG_ENDIAN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [7:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last
);
   generate
      if (AW > WORD_W || AW <= ALIGN_BITS) begin : g_bad_aw
         $error("AW must exceed ALIGN_BITS and fit in one word");
      end
      if (LEN_W > EOR_BIT - 2 || MIN_FRAME < 1 || MIN_FRAME >= (1 << LEN_W)) begin : g_bad_len
         $error("length field or minimum frame out of range");
      end
      if (DESC_BYTES != 16 || (1 << ALIGN_BITS) < DESC_BYTES) begin : g_bad_desc
         $error("descriptor size and ring alignment inconsistent");
      end
   endgenerate

   logic [AW-1:0]     ring_base;
   logic [AW-1:0]     base_new;
   logic              base_wr;
   logic              armed;
   logic              stop_req;
   logic [1:0]        lane;
   logic              in_payload;
   logic [WORD_W-1:0] word_q;

   tx_ring_regs #(.AW(AW), .ALIGN_BITS(ALIGN_BITS)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .stop_req(stop_req), .ring_base(ring_base),
      .base_new(base_new), .base_wr(base_wr), .armed(armed)
   );

   tx_ring_ctrl #(.AW(AW), .LEN_W(LEN_W), .MIN_FRAME(MIN_FRAME), .DESC_BYTES(DESC_BYTES)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .armed(armed), .ring_base(ring_base),
      .base_new(base_new), .base_wr(base_wr), .stop_req(stop_req),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
      .tx_last(tx_last), .lane(lane), .in_payload(in_payload), .word_q(word_q)
   );

   tx_lane_sel #(.BIG_ENDIAN(BIG_ENDIAN)) lane_i (
      .word(word_q), .lane(lane), .in_payload(in_payload), .byte_out(tx_data)
   );
endmodule

// File: rtl/txring_fetch_chk.sv
module txring_fetch_chk #(
   parameter int AW        = 32,
   parameter int MIN_FRAME = 60
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tx_valid,
   input logic          tx_last,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [31:0]   mem_wdata
);
   logic [31:0] beat_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)        beat_cnt <= '0;
      else if (tx_valid) beat_cnt <= tx_last ? '0 : beat_cnt + 1;
   end

   assert_min_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_last) |-> (beat_cnt >= 32'(MIN_FRAME - 1)));

   assert_last_is_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_last |-> tx_valid);

   assert_own_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> !mem_wdata[31]);

   assert_wr_desc_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |-> (mem_addr[3:0] == 4'h0));

   assert_rd_word_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |-> (mem_addr[1:0] == 2'b00));

   assert_no_mem_while_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !mem_req);
endmodule

bind txring_fetch txring_fetch_chk #(.AW(AW), .MIN_FRAME(MIN_FRAME)) chk_i (
   .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_last(tx_last),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/txring_fetch_tb_top.sv
`timescale 1ns/1ps
module txring_fetch_tb_top;
   localparam int AW = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic        mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata;
   logic        tx_valid, tx_last;
   logic [7:0]  tx_data;

   logic        tb_we = 1'b0;
   logic [31:0] tb_waddr = '0;
   logic [31:0] tb_wdata = '0;
   logic [31:0] mem [0:1023];

   int checks = 0, fails = 0, cycles = 0;
   int got_n = 0, wb_n = 0, rd_n = 0, misalign = 0;
   logic [7:0]  got [0:255];
   logic        got_last [0:255];
   logic [31:0] wb_addr = '0, wb_data = '0, last_rd = '0;

   // field layout: len[31:16] off[15:8] slot[7:4] eor[0]
   localparam logic [31:0] VEC [6] = '{
      {16'd64,  8'd0, 4'd0, 4'd0},
      {16'd10,  8'd1, 4'd1, 4'd0},
      {16'd61,  8'd2, 4'd2, 4'd1},
      {16'd0,   8'd0, 4'd0, 4'd0},
      {16'd60,  8'd3, 4'd1, 4'd0},
      {16'd100, 8'd1, 4'd2, 4'd1}
   };

   always #4 clk = ~clk;

   txring_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
   );

   always @(posedge clk) begin
      if (mem_req && mem_we)  mem[mem_addr[11:2]] <= mem_wdata;
      else if (tb_we)         mem[tb_waddr[11:2]] <= tb_wdata;
      if (mem_req && !mem_we) mem_rdata <= mem[mem_addr[11:2]];
   end

   always @(negedge clk) begin
      cycles++;
      if (tx_valid && got_n < 256) begin
         got[got_n] = tx_data;
         got_last[got_n] = tx_last;
         got_n++;
      end
      if (mem_req && mem_we) begin
         wb_n++; wb_addr = mem_addr; wb_data = mem_wdata;
      end
      if (mem_req && !mem_we) begin
         rd_n++; last_rd = mem_addr;
         if (mem_addr[1:0] != 2'b00) misalign++;
      end
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog expired: actual=%0d cycles expected=done", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   function automatic logic [7:0] pat(int a);
      return 8'(a * 29 + (a >>> 7) + 17);
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic mem_wr(int a, logic [31:0] d);
      @(negedge clk); tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
      @(negedge clk); tb_we = 1'b0;
   endtask

   task automatic reg_write(logic [7:0] a, logic [31:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   function automatic logic [31:0] mk_status(int len, bit eor);
      return {1'b1, eor, 2'b11, 12'h5A3, 16'(len)};
   endfunction

   task automatic setup_desc(int slot_a, int buf_a, int len, bit eor);
      for (int w = buf_a & ~3; w <= ((buf_a + len) | 3); w += 4)
         mem_wr(w, {pat(w + 3), pat(w + 2), pat(w + 1), pat(w)});
      mem_wr(slot_a + 4, 32'hDEAD_0004);   // R3: unused word
      mem_wr(slot_a + 12, 32'hDEAD_000C);  // R3: unused word
      mem_wr(slot_a + 8, buf_a);
      mem_wr(slot_a, mk_status(len, eor));
   endtask

   task automatic kick_and_check(int slot_a, int buf_a, int len, bit eor);
      int wb0, exp_n, bad, bad_k, lasts;
      logic [7:0] e;
      got_n = 0; wb0 = wb_n;
      reg_write(8'h38, 32'h40);
      for (int t = 0; t < 3000 && wb_n == wb0; t++) @(negedge clk);
      repeat (8) @(negedge clk);
      exp_n = (len < 60) ? 60 : len;
      check(got_n == exp_n, "R5 byte count", got_n, exp_n);
      bad = 0; bad_k = -1;
      for (int k = 0; k < exp_n && k < got_n; k++) begin
         e = (k < len) ? pat(buf_a + k) : 8'h00;
         if (got[k] !== e) begin bad++; if (bad_k < 0) bad_k = k; end
      end
      check(bad == 0, "R4 payload order and zero padding", bad_k < 0 ? 0 : got[bad_k],
            bad_k < 0 ? 0 : ((bad_k < len) ? pat(buf_a + bad_k) : 0));
      lasts = 0;
      for (int k = 0; k < got_n; k++) if (got_last[k]) lasts++;
      check(lasts == 1 && got_n > 0 && got_last[got_n - 1], "R6 last marker", lasts, 1);
      check(wb_n == wb0 + 1 && wb_addr == slot_a, "R8 write-back address", wb_addr, slot_a);
      check(wb_data == (mk_status(len, eor) & 32'h7FFF_FFFF), "R7 status write-back",
            wb_data, mk_status(len, eor) & 32'h7FFF_FFFF);
   endtask

   initial begin
      int r0, w0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int s = 0; s < 3; s++) mem_wr(32'h100 + 16 * s, 32'h0);
      mem_wr(32'h200, 32'h0);
      repeat (10) @(negedge clk);
      // R1: idle after reset
      check(got_n == 0 && rd_n == 0 && wb_n == 0, "R1 quiet after reset", rd_n + got_n, 0);
      reg_write(8'h20, 32'h100);

      // table-driven frames around a three-slot ring
      for (int i = 0; i < 6; i++) begin
         int len, off, slot_a, buf_a;
         bit eor;
         len = int'(VEC[i][31:16]); off = int'(VEC[i][15:8]);
         slot_a = 32'h100 + 16 * int'(VEC[i][7:4]); eor = VEC[i][0];
         buf_a = 32'h400 + 32'h80 * i + off;
         setup_desc(slot_a, buf_a, len, eor);
         kick_and_check(slot_a, buf_a, len, eor);
      end

      // R9: retired descriptor at ring base after the wrap
      got_n = 0; r0 = rd_n; w0 = wb_n;
      reg_write(8'h38, 32'h40);
      repeat (20) @(negedge clk);
      check(got_n == 0 && wb_n == w0, "R9 stop on unowned", got_n, 0);
      check(rd_n == r0 + 1 && last_rd == 32'h100, "R8 wrap to base", last_rd, 32'h100);

      // R9: handed over without doorbell stays untouched
      setup_desc(32'h100, 32'h700, 20, 1'b0);
      repeat (30) @(negedge clk);
      check(got_n == 0 && rd_n == r0 + 1, "R9 no fetch without doorbell", rd_n - r0, 1);
      // R2: doorbell byte with start bit clear
      reg_write(8'h38, 32'hBF);
      repeat (30) @(negedge clk);
      check(got_n == 0 && rd_n == r0 + 1, "R2 doorbell bit 6 clear ignored", rd_n - r0, 1);
      kick_and_check(32'h100, 32'h700, 20, 1'b0);

      // R10: base write with low bits set
      reg_write(8'h20, 32'h2A5);
      setup_desc(32'h200, 32'h782, 70, 1'b1);
      kick_and_check(32'h200, 32'h782, 70, 1'b1);
      check(wb_addr == 32'h200, "R10 aligned base", wb_addr, 32'h200);

      // R11: access discipline
      check(misalign == 0, "R11 word-aligned reads", misalign, 0);
      check(wb_n == 8, "R11 write-back count", wb_n, 8);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule